// File: doc/BRIEF.md
# Serial-Programmed Glitch-Free Clock Gate Bank

This block switches a bank of twelve clock lanes on and off one lane at a time. A two-wire serial port sets the pattern. The port has a free-running serial clock and a data line that stays high when no frame is being sent. To send a frame, the host drives a low start bit and then one enable bit per gated lane. Each bit lasts one serial clock period, and the block samples it on the rising edge. When the last bit arrives, the whole pattern is loaded at once into the active enable register. Each lane then picks up its new enable inside its own clock domain.

A lane may stop or restart only while its input clock is low. A stopped lane is held at logic 0. So a gated output never shows a high pulse shorter than a full high phase of its input clock. Two further lanes have no enable bit and always pass their input clock through. The clocks to be gated come in as inputs. Clock generation and division are outside this block.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset is released, every gated lane runs: its output follows its input clock.
- R2: While idle, a 0 sampled on a rising serial clock edge is taken as a start bit. The next 12 rising edges each sample one data bit.
- R3: Data bits map to lanes in arrival order: the first bit after the start bit controls lane 0 (`gclk_o[0]`), and the twelfth controls lane 11. A 1 lets the lane run and a 0 stops it.
- R4: A stopped lane's output stays at logic 0 for as long as it is stopped.
- R5: While idle, a data line held high is ignored and the enable pattern does not change.
- R6: The active pattern changes only at the edge that samples the twelfth data bit, and then all lanes change together. A frame still being received never changes any output.
- R7: A gated output starts or stops only while its input clock is low. Every high pulse it produces lasts exactly one full high phase of its input clock.
- R8: Each free-running output equals its input clock at all times.
- R9: After the twelfth data bit the receiver returns to idle. A start bit on the very next rising edge begins a new frame, so frames may be sent back to back.
- R10: Each lane applies a new enable after two rising edges of its own clock through a synchronizer, then on the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk_i | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data line; high when idle, low start bit, then 12 enable bits |
| gclk_i | input | 12 | Clocks to be gated, one per lane |
| fclk_i | input | 2 | Clocks for the lanes that always run |
| gclk_o | output | 12 | Gated clock outputs |
| fclk_o | output | 2 | Ungated clock outputs |

## Verification
The assertions assume several things about the inputs:
- The serial data line changes only away from the rising serial clock edge.
- Reset is asserted only while the lanes are running.
- Each lane clock toggles cleanly and has no edge at the same instant its synchronized enable is captured.

The bench meets these assumptions in three ways:
- It drives data only on falling serial edges.
- It applies reset once, at start-up, while all enables are 1.
- It gives each lane an integer half-period and samples at fractional times.

Randomized frames with random idle gaps stop and restart lanes at unrelated moments. This exercises the low-phase switching rule across every phase offset between the serial clock and the lane clocks.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/clkstop_ser_rx.sv
module clkstop_ser_rx
  import clkstop_pkg::*;
#(
  parameter int unsigned NG = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  data_i,
  output logic [NG-1:0]         en_o,
  output rx_state_e             state_o,
  output logic [$clog2(NG)-1:0] cnt_o
);
  localparam int unsigned CW = $clog2(NG);
  localparam logic [CW-1:0] LAST = CW'(NG - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [NG-1:0] shift_q, shift_d, en_q;
  logic          last_bit;

  assign last_bit = (state_q == RX_SHIFT) && (cnt_q == LAST);

  // bit k of the frame lands on lane k
  always_comb begin
    shift_d = shift_q;
    shift_d[cnt_q] = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shift_q <= '1;
      en_q    <= '1;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!data_i) state_q <= RX_SHIFT;
        end
        RX_SHIFT: begin
          shift_q <= shift_d;
          if (last_bit) begin
            en_q    <= shift_d;   // whole pattern in one step
            state_q <= RX_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign en_o    = en_q;
  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o,
  output logic en_q_o
);
  logic en_sync;
  logic en_lo_q;

  clkstop_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_i),
    .q_o   (en_sync)
  );

  // capture in the low phase so the AND never clips a high pulse
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_lo_q <= 1'b1;
    else         en_lo_q <= en_sync;
  end

  assign clk_o  = clk_i & en_lo_q;
  assign en_q_o = en_lo_q;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned NG          = 12,
  parameter int unsigned NF          = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          ser_clk_i,
  input  logic          rst_ni,
  input  logic          ser_data_i,
  input  logic [NG-1:0] gclk_i,
  input  logic [NF-1:0] fclk_i,
  output logic [NG-1:0] gclk_o,
  output logic [NF-1:0] fclk_o
);
  localparam int unsigned CW = $clog2(NG);

  logic [NG-1:0] act_en;
  logic [NG-1:0] gate_en;
  rx_state_e     rx_state;
  logic [CW-1:0] rx_cnt;

  clkstop_ser_rx #(.NG(NG)) u_rx (
    .clk_i  (ser_clk_i),
    .rst_ni (rst_ni),
    .data_i (ser_data_i),
    .en_o   (act_en),
    .state_o(rx_state),
    .cnt_o  (rx_cnt)
  );

  for (genvar g = 0; g < NG; g++) begin : g_lane
    clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_i (gclk_i[g]),
      .rst_ni(rst_ni),
      .en_i  (act_en[g]),
      .clk_o (gclk_o[g]),
      .en_q_o(gate_en[g])
    );
  end

  for (genvar f = 0; f < NF; f++) begin : g_free
    assign fclk_o[f] = fclk_i[f];
  end
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk
  import clkstop_pkg::*;
#(
  parameter int unsigned NG = 12
) (
  input logic                  ser_clk_i,
  input logic                  rst_ni,
  input logic                  ser_data_i,
  input rx_state_e             rx_state,
  input logic [$clog2(NG)-1:0] rx_cnt,
  input logic [NG-1:0]         act_en,
  input logic [NG-1:0]         gclk_i,
  input logic [NG-1:0]         gate_en
);
  localparam int unsigned CW = $clog2(NG);
  localparam logic [CW-1:0] LAST = CW'(NG - 1);

  assert_idle_hold_R5: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    (rx_state == RX_IDLE && ser_data_i) |=> (rx_state == RX_IDLE && $stable(act_en)));

  assert_start_R2: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    (rx_state == RX_IDLE && !ser_data_i) |=> (rx_state == RX_SHIFT && rx_cnt == '0));

  assert_step_R2: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    (rx_state == RX_SHIFT && rx_cnt != LAST) |=>
      (rx_state == RX_SHIFT && rx_cnt == CW'($past(rx_cnt) + 1'b1)));

  assert_atomic_R6: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    !(rx_state == RX_SHIFT && rx_cnt == LAST) |=> $stable(act_en));

  assert_last_bit_R3: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    (rx_state == RX_SHIFT && rx_cnt == LAST) |=> (act_en[NG-1] == $past(ser_data_i)));

  assert_back_idle_R9: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    (rx_state == RX_SHIFT && rx_cnt == LAST) |=> (rx_state == RX_IDLE));

  for (genvar k = 0; k < NG; k++) begin : g_lane_chk
    always @(gate_en[k]) begin
      if (rst_ni === 1'b1) begin
        assert_chg_low_R7: assert (gclk_i[k] == 1'b0)
          else $error("lane %0d enable moved while clock high", k);
      end
    end
  end
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.NG(NG)) u_chk (
  .ser_clk_i (ser_clk_i),
  .rst_ni    (rst_ni),
  .ser_data_i(ser_data_i),
  .rx_state  (rx_state),
  .rx_cnt    (rx_cnt),
  .act_en    (act_en),
  .gclk_i    (gclk_i),
  .gate_en   (gate_en)
);

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb;
  localparam int NG = 12;
  localparam int NF = 2;

  logic          ser_clk = 1'b0;
  logic          rst_n   = 1'b0;
  logic          ser_data = 1'b1;
  logic [NG-1:0] gclk_i;
  logic [NF-1:0] fclk_i;
  logic [NG-1:0] gclk_o;
  logic [NF-1:0] fclk_o;

  int vec = 0;
  int misc = 0;
  bit timeout = 0;

  always #2.5 ser_clk = ~ser_clk;

  // lane k half period = (3+k) ns
  for (genvar g = 0; g < NG; g++) begin : g_gclk
    logic c = 1'b0;
    always #(3 + g) c = ~c;
    assign gclk_i[g] = c;
  end
  for (genvar f = 0; f < NF; f++) begin : g_fclk
    logic c = 1'b0;
    always #(4 + 2 * f) c = ~c;
    assign fclk_i[f] = c;
  end

  clkstop_ctrl u_dut (
    .ser_clk_i (ser_clk),
    .rst_ni    (rst_n),
    .ser_data_i(ser_data),
    .gclk_i    (gclk_i),
    .fclk_i    (fclk_i),
    .gclk_o    (gclk_o),
    .fclk_o    (fclk_o)
  );

  // pulse-width monitor (R7, R4)
  realtime       rise_t[NG];
  logic [NG-1:0] prev_o = '0;
  int            runt_fail = 0;
  int            pulses = 0;
  always @(gclk_o) begin
    for (int k = 0; k < NG; k++) begin
      if (gclk_o[k] !== prev_o[k]) begin
        if (gclk_o[k] === 1'b1) begin
          rise_t[k] = $realtime;
          if (gclk_i[k] !== 1'b1) runt_fail++;
        end else if (prev_o[k] === 1'b1) begin
          pulses++;
          if ($realtime - rise_t[k] < real'(3 + k) - 0.001 ||
              $realtime - rise_t[k] > real'(3 + k) + 0.001) runt_fail++;
        end
        prev_o[k] = gclk_o[k];
      end
    end
  end

  task automatic send_bits(input logic [NG-1:0] bits);
    @(negedge ser_clk) ser_data = 1'b0;
    for (int k = 0; k < NG; k++) begin
      @(negedge ser_clk) ser_data = bits[k];
    end
  endtask

  task automatic send_frame(input logic [NG-1:0] bits);
    send_bits(bits);
    @(negedge ser_clk) ser_data = 1'b1;
  endtask

  task automatic settle();
    #150;
  endtask

  task automatic check_pattern(input logic [NG-1:0] exp, input string req);
    logic [NG-1:0] seen = '0;
    bit fbad = 1'b0;
    #0.2;
    repeat (90) begin
      #0.5;
      seen |= gclk_o;
      if (fclk_o !== fclk_i) fbad = 1'b1;
    end
    for (int k = 0; k < NG; k++) begin
      vec++;
      if (seen[k] !== exp[k]) begin
        misc++;
        $display("FAIL %s lane %0d running=%0b expected=%0b", req, k, seen[k], exp[k]);
      end
    end
    vec++;
    if (fbad) begin
      misc++;
      $display("FAIL R8 free outputs differ from inputs: actual=mismatch expected=equal");
    end
  endtask

  task automatic t_reset();
    check_pattern('1, "R1");
  endtask

  task automatic t_order();
    send_frame(12'hFFE);           // only first bit 0 -> lane 0 stops
    settle();
    check_pattern(12'hFFE, "R3");
    send_frame(12'h7FF);           // only last bit 0 -> lane 11 stops
    settle();
    check_pattern(12'h7FF, "R3");
    send_frame(12'hA5C);
    settle();
    check_pattern(12'hA5C, "R4");
  endtask

  task automatic t_idle_ignored();
    @(negedge ser_clk) ser_data = 1'b1;
    repeat (40) @(negedge ser_clk);
    check_pattern(12'hA5C, "R5");
  endtask

  task automatic t_atomic();
    logic [NG-1:0] seen = '0;
    bit done = 1'b0;
    send_frame('0);
    settle();
    check_pattern('0, "R2");
    fork
      begin send_bits('1); done = 1'b1; end
      begin
        while (!done) begin #0.3; seen |= gclk_o; end
      end
    join
    @(negedge ser_clk) ser_data = 1'b1;
    vec++;
    if (seen !== '0) begin
      misc++;
      $display("FAIL R6 outputs moved mid-frame: actual=%h expected=000", seen);
    end
    settle();
    check_pattern('1, "R6");
  endtask

  task automatic t_back_to_back();
    send_bits(12'h0F0);
    send_bits(12'h3C3);            // start bit on the very next edge
    @(negedge ser_clk) ser_data = 1'b1;
    settle();
    check_pattern(12'h3C3, "R9");
  endtask

  task automatic t_latency();
    // lane 0: 2 rising edges (6 ns apart) + falling edge, well under 30 ns
    send_frame(12'hFFE);
    #30;
    check_pattern(12'hFFE, "R10");
  endtask

  task automatic t_stress();
    logic [NG-1:0] pat = '1;
    for (int n = 0; n < 40; n++) begin
      pat = NG'($urandom);
      send_bits(pat);
      @(negedge ser_clk) ser_data = 1'b1;
      repeat ($urandom_range(0, 5)) @(negedge ser_clk);
    end
    settle();
    check_pattern(pat, "R3");
    vec++;
    if (runt_fail != 0 || pulses == 0) begin
      misc++;
      $display("FAIL R7 short pulses=%0d (pulses seen %0d) expected=0", runt_fail, pulses);
    end
  endtask

  initial begin
    fork
      begin
        #23 rst_n = 1'b1;
        t_reset();
        t_order();
        t_idle_ignored();
        t_atomic();
        t_back_to_back();
        t_latency();
        t_stress();
      end
      begin
        #900000;
        timeout = 1'b1;
      end
    join_any
    if (timeout) begin
      vec++;
      misc++;
      $display("FAIL watchdog expired: actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, misc);
    $finish;
  end
endmodule